// File: doc/BRIEF.md
# Dual-Source Core Clock Divider

The block derives the core clock phase from two oscillator sources, a main source and a slower sub source. Both sources are presented on one fast reference clock as single-cycle tick strobes, one per source edge. The block answers with a single-cycle enable pulse, `phi_en`, once per core clock period. The logic the block clocks then advances only on cycles where `phi_en` is high.

A two-bit mode request chooses one of three divisions:

| Code | Mode | Division |
|------|------|----------|
| 00 | middle | main source divided by 8; the mode after reset |
| 01 | high | main source divided by 2 |
| 10 | low | sub source divided by 2 |

Code 11 is reserved and is never adopted.

A mode change is applied only on the edge that completes the current divided period. The new count then starts from zero. The sub source runs only when enabled. Once the core is running from the sub source, the main source can be gated off to save power. Software must keep the main frequency above three times the sub frequency whenever it moves between the two sources. The block relies on that ratio and does not measure it.

Top module: `clk_mode_div`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `mode_now` is 00 (middle), `phi_en` is 0, `main_on` is 1, `sub_on` is 0, and the divider count is zero.
- R2: In middle mode (`mode_now`=00), `phi_en` pulses for exactly one cycle after the clock edge that samples every eighth accepted main tick.
- R3: In high mode (`mode_now`=01), `phi_en` pulses for one cycle after the edge that samples every second accepted main tick.
- R4: In low mode (`mode_now`=10), `phi_en` pulses after the edge that samples every second sub tick, and main ticks have no effect.
- R5: A `mode_req` of 11 is never adopted; the current mode and its pulse rate continue.
- R6: A differing legal `mode_req` is adopted only on the edge that samples the terminal tick of the current mode. That edge still yields `phi_en`, and the first pulse in the new mode comes after a full period of the new mode.
- R7: Outside low mode, `sub_on` follows `sub_en` one edge later. A request for low mode is accepted only when both `sub_on` and `sub_en` are 1.
- R8: `main_stop_req` clears `main_on` one edge after it is sampled while `mode_now` is low mode. While `mode_now` is any other mode it has no effect, and `main_on` stays 1.
- R9: While `main_on` is 0, main ticks are ignored. A request for middle or high mode is accepted only when `main_on` is 1 and `main_stop_req` is 0. Clearing `main_stop_req` in low mode sets `main_on` again one edge later.
- R10: While `mode_now` is low mode, `sub_on` stays 1 even if `sub_en` is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| main_tick | input | 1 | One-cycle strobe per main source edge |
| sub_tick | input | 1 | One-cycle strobe per sub source edge |
| mode_req | input | 2 | Requested mode: 00 middle, 01 high, 10 low, 11 reserved |
| main_stop_req | input | 1 | Request to gate the main source off |
| sub_en | input | 1 | Enable for the sub source |
| phi_en | output | 1 | One-cycle pulse per core clock period |
| mode_now | output | 2 | Mode currently in force, same encoding as `mode_req` |
| main_on | output | 1 | Main source is running |
| sub_on | output | 1 | Sub source is running |

## Verification
Two things can meet on a single edge: a source-domain switch and a stop request for the main source. The bench raises the low-mode request and the stop request together while high mode is running. It then samples `main_on` on the switching edge, where it must still be 1, and on the edge after it, where it must be 0. Main and sub ticks are also made to coincide on the terminal edge. Only the tick of the source in force before the switch may count. A request to return to middle mode while the stop request is held must be refused.

// File: rtl/clk_mode_div_pkg.sv
package clk_mode_div_pkg;

  typedef enum logic [1:0] {
    MD_MID  = 2'b00,
    MD_HIGH = 2'b01,
    MD_LOW  = 2'b10,
    MD_RSV  = 2'b11
  } clk_mode_e;

endpackage

// File: rtl/cmd_osc_gate.sv
module cmd_osc_gate
  import clk_mode_div_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      main_stop_req,
  input  logic      sub_en,
  input  clk_mode_e mode_act,
  output logic      main_on,
  output logic      sub_on
);

  logic in_low;
  assign in_low = (mode_act == MD_LOW);

  // main gated off only while the sub clock drives the core
  always_ff @(posedge clk) begin
    if (rst) begin
      main_on <= 1'b1;
      sub_on  <= 1'b0;
    end else begin
      main_on <= !(main_stop_req && in_low);
      sub_on  <= sub_en || in_low;
    end
  end

endmodule

// File: rtl/cmd_mode_sel.sv
module cmd_mode_sel
  import clk_mode_div_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] mode_req,
  input  logic      term,
  input  logic      main_on,
  input  logic      main_stop_req,
  input  logic      sub_on,
  input  logic      sub_en,
  output clk_mode_e mode_act
);

  clk_mode_e req_m;
  logic      req_ok;

  assign req_m = clk_mode_e'(mode_req);

  always_comb begin
    unique case (req_m)
      MD_MID, MD_HIGH: req_ok = main_on && !main_stop_req;
      MD_LOW:          req_ok = sub_on && sub_en;
      default:         req_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      mode_act <= MD_MID;
    else if (term && req_ok)
      mode_act <= req_m;
  end

endmodule

// File: rtl/cmd_phase_div.sv
module cmd_phase_div
  import clk_mode_div_pkg::*;
#(
  parameter int DIV_MID  = 8,
  parameter int DIV_HIGH = 2,
  parameter int DIV_LOW  = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      main_tick,
  input  logic      sub_tick,
  input  logic      main_on,
  input  logic      sub_on,
  input  clk_mode_e mode_act,
  output logic      term,
  output logic      phi_en
);

  localparam int MAX_AB = (DIV_MID > DIV_HIGH) ? DIV_MID : DIV_HIGH;
  localparam int MAX_D  = (MAX_AB > DIV_LOW) ? MAX_AB : DIV_LOW;
  localparam int CNT_W  = (MAX_D > 2) ? $clog2(MAX_D) : 1;
  localparam logic [CNT_W-1:0] LIM_MID  = CNT_W'(DIV_MID - 1);
  localparam logic [CNT_W-1:0] LIM_HIGH = CNT_W'(DIV_HIGH - 1);
  localparam logic [CNT_W-1:0] LIM_LOW  = CNT_W'(DIV_LOW - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             src_tick;

  always_comb begin
    unique case (mode_act)
      MD_HIGH: begin lim = LIM_HIGH; src_tick = main_tick && main_on; end
      MD_LOW:  begin lim = LIM_LOW;  src_tick = sub_tick && sub_on;   end
      default: begin lim = LIM_MID;  src_tick = main_tick && main_on; end
    endcase
  end

  assign term = src_tick && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      phi_en <= 1'b0;
    end else begin
      phi_en <= term;
      if (term)
        cnt <= '0;
      else if (src_tick)
        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/clk_mode_div.sv
module clk_mode_div
  import clk_mode_div_pkg::*;
#(
  parameter int DIV_MID  = 8,
  parameter int DIV_HIGH = 2,
  parameter int DIV_LOW  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic [1:0] mode_req,
  input  logic       main_stop_req,
  input  logic       sub_en,
  output logic       phi_en,
  output logic [1:0] mode_now,
  output logic       main_on,
  output logic       sub_on
);

  clk_mode_e mode_act;
  logic      term;

  cmd_osc_gate u_gate (
    .clk           (clk),
    .rst           (rst),
    .main_stop_req (main_stop_req),
    .sub_en        (sub_en),
    .mode_act      (mode_act),
    .main_on       (main_on),
    .sub_on        (sub_on)
  );

  cmd_mode_sel u_sel (
    .clk           (clk),
    .rst           (rst),
    .mode_req      (mode_req),
    .term          (term),
    .main_on       (main_on),
    .main_stop_req (main_stop_req),
    .sub_on        (sub_on),
    .sub_en        (sub_en),
    .mode_act      (mode_act)
  );

  cmd_phase_div #(
    .DIV_MID  (DIV_MID),
    .DIV_HIGH (DIV_HIGH),
    .DIV_LOW  (DIV_LOW)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .main_tick (main_tick),
    .sub_tick  (sub_tick),
    .main_on   (main_on),
    .sub_on    (sub_on),
    .mode_act  (mode_act),
    .term      (term),
    .phi_en    (phi_en)
  );

  assign mode_now = mode_act;

endmodule

// File: rtl/clk_mode_div_chk.sv
module clk_mode_div_chk
  import clk_mode_div_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       main_tick,
  input logic       sub_tick,
  input logic       phi_en,
  input logic [1:0] mode_now,
  input logic       main_on,
  input logic       sub_on
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (mode_now == MD_MID && !phi_en && main_on && !sub_on)); // R1

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    phi_en |=> !phi_en); // R2

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (rst)
    mode_now != MD_RSV); // R5

  AST_SWITCH_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_now) |-> phi_en); // R6

  AST_STOP_ONLY_LOW: assert property (@(posedge clk) disable iff (rst)
    !main_on |-> mode_now == MD_LOW); // R8

  AST_PULSE_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    phi_en |-> ($past(mode_now) == MD_LOW ? $past(sub_tick)
                                          : $past(main_tick && main_on))); // R9

  AST_LOW_KEEPS_SUB: assert property (@(posedge clk) disable iff (rst)
    mode_now == MD_LOW |-> sub_on); // R10

endmodule

bind clk_mode_div clk_mode_div_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .main_tick (main_tick),
  .sub_tick  (sub_tick),
  .phi_en    (phi_en),
  .mode_now  (mode_now),
  .main_on   (main_on),
  .sub_on    (sub_on)
);

// File: tb/tb_clk_mode_div.sv
`timescale 1ns/1ps
module tb_clk_mode_div;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       main_tick = 1'b0;
  logic       sub_tick = 1'b0;
  logic [1:0] mode_req = 2'b00;
  logic       main_stop_req = 1'b0;
  logic       sub_en = 1'b0;
  logic       phi_en;
  logic [1:0] mode_now;
  logic       main_on;
  logic       sub_on;

  localparam logic [1:0] M_MID = 2'b00, M_HIGH = 2'b01, M_LOW = 2'b10, M_RSV = 2'b11;

  clk_mode_div dut (
    .clk(clk), .rst(rst), .main_tick(main_tick), .sub_tick(sub_tick),
    .mode_req(mode_req), .main_stop_req(main_stop_req), .sub_en(sub_en),
    .phi_en(phi_en), .mode_now(mode_now), .main_on(main_on), .sub_on(sub_on)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  typedef struct {
    int         at;
    logic [1:0] mode;
    string      req;
  } exp_t;
  exp_t sb[$];

  // bench-side expectation state
  logic [1:0] exp_mode = M_MID;
  logic [1:0] model_next = M_MID;
  int         exp_cnt = 0;
  bit         exp_main_on = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] m);
    return (m == M_MID) ? 8 : 2;
  endfunction

  // driver: called at a negedge; tick sampled on the next posedge
  task automatic tick(input bit m, input bit s, input int gap, input string req);
    bit   counts;
    exp_t e;
    main_tick = m;
    sub_tick  = s;
    counts = (exp_mode == M_LOW) ? s : (m && exp_main_on);
    if (counts) begin
      exp_cnt++;
      if (exp_cnt == div_of(exp_mode)) begin
        exp_cnt  = 0;
        exp_mode = model_next;
        e.at = cyc + 1; e.mode = exp_mode; e.req = req;
        sb.push_back(e);
      end
    end
    @(negedge clk);
    main_tick = 1'b0;
    sub_tick  = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && phi_en) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2", "unexpected phi_en at cycle", cyc, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.at, e.req, "phi_en cycle", cyc, e.at);
        chk(mode_now == e.mode, e.req, "mode_now at pulse", int'(mode_now), int'(e.mode));
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(mode_now == M_MID, "R1", "reset mode_now", int'(mode_now), 0);
    chk(phi_en == 1'b0, "R1", "reset phi_en", int'(phi_en), 0);
    chk(main_on == 1'b1, "R1", "reset main_on", int'(main_on), 1);
    chk(sub_on == 1'b0, "R1", "reset sub_on", int'(sub_on), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mode_now == M_MID && !phi_en, "R1", "state after reset release", int'(mode_now), 0);

    // R2: middle mode, varied spacing, sub ticks ignored
    for (int i = 0; i < 16; i++) tick(1'b1, i[0], i % 3, "R2");

    // R8: stop request outside low mode has no effect
    main_stop_req = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(main_on == 1'b1, "R8", "main_on with stop in middle", int'(main_on), 1);
    for (int i = 0; i < 8; i++) tick(1'b1, 1'b0, 0, "R8");
    main_stop_req = 1'b0;

    // R5: reserved code ignored
    mode_req = M_RSV;
    for (int i = 0; i < 8; i++) tick(1'b1, 1'b0, 1, "R5");
    chk(mode_now == M_MID, "R5", "mode after reserved request", int'(mode_now), 0);

    // R6/R3: switch to high only at terminal count
    mode_req = M_HIGH; model_next = M_HIGH;
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 0, "R6");
    chk(mode_now == M_MID, "R6", "mode before terminal", int'(mode_now), 0);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 0, "R6");
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b1, i % 2, "R3");

    // R7: low request refused without sub enable
    mode_req = M_LOW;
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 0, "R7");
    chk(mode_now == M_HIGH, "R7", "low refused without sub", int'(mode_now), 1);
    chk(sub_on == 1'b0, "R7", "sub_on while disabled", int'(sub_on), 0);
    sub_en = 1'b1;
    @(negedge clk);
    chk(sub_on == 1'b1, "R7", "sub_on after enable", int'(sub_on), 1);

    // same-edge: switch to low together with stop request
    model_next = M_LOW; main_stop_req = 1'b1;
    tick(1'b1, 1'b0, 0, "R6");
    chk(main_on == 1'b1, "R8", "main_on before low active", int'(main_on), 1);
    tick(1'b1, 1'b1, 0, "R6");
    chk(mode_now == M_LOW, "R6", "mode on switch edge", int'(mode_now), 2);
    chk(main_on == 1'b1, "R8", "main_on on switch edge", int'(main_on), 1);
    @(negedge clk);
    chk(main_on == 1'b0, "R8", "main_on one edge later", int'(main_on), 0);
    exp_main_on = 1'b0;

    // R4/R9: low mode, main ticks ignored, return to middle refused while stopped
    mode_req = M_MID;
    tick(1'b0, 1'b1, 1, "R4");
    tick(1'b1, 1'b0, 0, "R4");
    tick(1'b0, 1'b1, 0, "R4");
    tick(1'b1, 1'b1, 0, "R9");
    tick(1'b1, 1'b1, 2, "R9");
    chk(mode_now == M_LOW, "R9", "middle refused while stopped", int'(mode_now), 2);

    // R10: sub stays on while low
    sub_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(sub_on == 1'b1, "R10", "sub_on held in low", int'(sub_on), 1);

    // R9: restart main then return to middle
    main_stop_req = 1'b0;
    @(negedge clk);
    chk(main_on == 1'b1, "R9", "main_on after stop cleared", int'(main_on), 1);
    exp_main_on = 1'b1; model_next = M_MID;
    tick(1'b0, 1'b1, 0, "R6");
    tick(1'b0, 1'b1, 0, "R6");
    chk(mode_now == M_MID, "R6", "back to middle", int'(mode_now), 0);
    @(negedge clk);
    chk(sub_on == 1'b0, "R7", "sub_on follows disable", int'(sub_on), 0);
    for (int i = 0; i < 8; i++) tick(1'b1, 1'b0, 1, "R6");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R2", "pulses still pending", sb.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule